// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block accepts one decoded multiple-register load or store and breaks it into single-register micro-operations. It issues them one at a time over a valid/ready handshake. The first micro-op always copies the base register, plus zero, into a temporary base. Each transfer then addresses memory as a signed byte offset from that temporary. A trailing op can write back the base register.

The instruction is presented with a 16-bit register mask, the base register number and five control bits:
- `pre_inc`: apply the offset before the access.
- `ascend`: addresses go upward.
- `usr_bank`: force transfers to the user register bank.
- `wb_en`: write the base register back.
- `is_load`: load rather than store.

The sequencer takes a new instruction only while idle (`cmd_ready` high). The last micro-op of the stream carries `uop_last`.

Top module: `ldm_uop_seq`

## Requirements
- R1: After reset, `uop_valid` is 0 and `cmd_ready` is 1.
- R2: The number of micro-ops in an instruction's stream equals popcount(mask) + 1, plus 1 more when `wb_en` is set. `uop_last` is 1 only on the final one.
- R3: The first micro-op has kind BASE (encoding 0), target equal to the base register number, offset 0 and force flag 0.
- R4: Transfers address registers in ascending index order, one per set mask bit.
- R5: The first transfer offset is 0 when `ascend`=1 and 4*N-4 when `ascend`=0, where N is the popcount. It is then increased by 4 when `pre_inc`=1.
- R6: After each transfer the offset moves by +4 when `ascend`=1 and by -4 otherwise.
- R7: The transfer kind is LOAD (encoding 1) when `is_load`=1 and STORE (encoding 2) otherwise.
- R8: When `usr_bank`=1, each transfer's `uop_reg` is the architectural index plus 16 and `uop_force_usr`=1. Otherwise the index is unchanged and the flag is 0.
- R9: When `wb_en`=1, the final micro-op has kind WBACK (encoding 3), target equal to the base, and offset +4*N when ascending or -4*N when descending.
- R10: A command offered while a stream is in progress is not accepted (`cmd_ready`=0) and does not alter the stream.
- R11: A micro-op is held stable while `uop_valid`=1 and `uop_ready`=0.
- R12: An empty mask yields only the BASE op and, if requested, the WBACK op. The WBACK offset in that case is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Sequencer idle and able to accept |
| cmd_mask | input | 16 | Register list |
| cmd_base | input | 4 | Base register number |
| cmd_pre_inc | input | 1 | Pre-index control |
| cmd_ascend | input | 1 | Up/down control |
| cmd_usr_bank | input | 1 | Force user bank |
| cmd_wb_en | input | 1 | Base writeback requested |
| cmd_is_load | input | 1 | Load (1) or store (0) |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_kind | output | 2 | 0 BASE, 1 LOAD, 2 STORE, 3 WBACK |
| uop_reg | output | 5 | Target register index (bank-forced index is index+16) |
| uop_force_usr | output | 1 | User bank forced |
| uop_offset | output | 8 | Signed byte offset |
| uop_last | output | 1 | Final micro-op of the stream |

## Verification
Two things can meet in one cycle: the final micro-op being consumed, and a new instruction arriving. The bench drives `cmd_valid` continuously through a whole stream, with the next command ready. This checks that the command is refused while a stream is busy and taken only once the sequencer is idle again. The bench also stalls `uop_ready` at random while a stream is in progress, so that an offset update and a hold can fall on neighbouring edges. A queue-based reference model compares every handshake of the stream against what it predicts.

// File: rtl/ldm_uop_pkg.sv
package ldm_uop_pkg;
    localparam int NREG  = 16;
    localparam int RIDW  = $clog2(NREG);
    localparam int OFFW  = 8;
    localparam int WORDB = 4;

    typedef enum logic [1:0] {
        UK_BASE  = 2'd0,
        UK_LOAD  = 2'd1,
        UK_STORE = 2'd2,
        UK_WBACK = 2'd3
    } uop_kind_e;

    typedef struct packed {
        logic pre_inc;
        logic ascend;
        logic usr_bank;
        logic wb_en;
        logic is_load;
    } ctl_t;

    typedef struct packed {
        uop_kind_e         kind;
        logic [RIDW:0]     rid;
        logic              force_usr;
        logic signed [OFFW-1:0] off;
        logic              last;
    } uop_t;

    function automatic logic [RIDW:0] popcnt(input logic [NREG-1:0] m);
        logic [RIDW:0] c;
        c = '0;
        for (int i = 0; i < NREG; i++) c = c + {{RIDW{1'b0}}, m[i]};
        return c;
    endfunction
endpackage

// File: rtl/ldm_lowbit.sv
module ldm_lowbit
    import ldm_uop_pkg::*;
#(
    parameter int W = NREG
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx,
    output logic [W-1:0]         rest
);
    logic [W-1:0] iso;
    always_comb begin
        iso  = vec & (~vec + 1'b1);
        rest = vec & ~iso;
        idx  = '0;
        for (int i = W - 1; i >= 0; i--)
            if (vec[i]) idx = i[$clog2(W)-1:0];
    end
endmodule

// File: rtl/ldm_offset_calc.sv
module ldm_offset_calc
    import ldm_uop_pkg::*;
(
    input  logic [RIDW:0]          cnt,
    input  logic                   ascend,
    input  logic                   pre_inc,
    output logic signed [OFFW-1:0] start_off,
    output logic signed [OFFW-1:0] step,
    output logic signed [OFFW-1:0] wb_off
);
    logic signed [OFFW-1:0] span;
    always_comb begin
        span = OFFW'(cnt) * OFFW'(WORDB);
        if (ascend) start_off = '0;
        else        start_off = span - OFFW'(WORDB);
        if (pre_inc) start_off = start_off + OFFW'(WORDB);
        step   = ascend ? OFFW'(WORDB) : -OFFW'(WORDB);
        wb_off = ascend ? span : -span;
    end
endmodule

// File: rtl/ldm_uop_seq.sv
module ldm_uop_seq
    import ldm_uop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [15:0] cmd_mask,
    input  logic [3:0]  cmd_base,
    input  logic        cmd_pre_inc,
    input  logic        cmd_ascend,
    input  logic        cmd_usr_bank,
    input  logic        cmd_wb_en,
    input  logic        cmd_is_load,
    output logic        uop_valid,
    input  logic        uop_ready,
    output logic [1:0]  uop_kind,
    output logic [4:0]  uop_reg,
    output logic        uop_force_usr,
    output logic [7:0]  uop_offset,
    output logic        uop_last
);
    typedef enum logic [1:0] {S_IDLE, S_BASE, S_XFER, S_WB} st_e;

    st_e                    st_q;
    logic [NREG-1:0]        mask_q;
    logic [RIDW-1:0]        base_q;
    ctl_t                   ctl_q;
    logic signed [OFFW-1:0] off_q, step_q, wbo_q;

    logic [RIDW:0]          cnt_in;
    logic signed [OFFW-1:0] so_in, st_in, wb_in;
    logic [RIDW-1:0]        low_idx;
    logic [NREG-1:0]        low_rest;
    uop_t                   cur;
    logic                   fire, accept;

    assign cnt_in = popcnt(cmd_mask);

    ldm_offset_calc u_off (
        .cnt(cnt_in), .ascend(cmd_ascend), .pre_inc(cmd_pre_inc),
        .start_off(so_in), .step(st_in), .wb_off(wb_in)
    );

    ldm_lowbit #(.W(NREG)) u_low (.vec(mask_q), .idx(low_idx), .rest(low_rest));

    assign cmd_ready = (st_q == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign uop_valid = (st_q != S_IDLE);
    assign fire      = uop_valid && uop_ready;

    always_comb begin
        cur = '{kind: UK_BASE, rid: '0, force_usr: 1'b0, off: '0, last: 1'b0};
        unique case (st_q)
            S_BASE: begin
                cur.kind = UK_BASE;
                cur.rid  = {1'b0, base_q};
                cur.last = (mask_q == '0) && !ctl_q.wb_en;
            end
            S_XFER: begin
                cur.kind      = ctl_q.is_load ? UK_LOAD : UK_STORE;
                cur.force_usr = ctl_q.usr_bank;
                cur.rid       = ctl_q.usr_bank ? ({1'b0, low_idx} + (RIDW+1)'(NREG))
                                               : {1'b0, low_idx};
                cur.off       = off_q;
                cur.last      = (low_rest == '0) && !ctl_q.wb_en;
            end
            S_WB: begin
                cur.kind = UK_WBACK;
                cur.rid  = {1'b0, base_q};
                cur.off  = wbo_q;
                cur.last = 1'b1;
            end
            default: ;
        endcase
    end

    assign uop_kind      = cur.kind;
    assign uop_reg       = cur.rid;
    assign uop_force_usr = cur.force_usr;
    assign uop_offset    = cur.off;
    assign uop_last      = cur.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            mask_q <= '0;
            base_q <= '0;
            ctl_q  <= '0;
            off_q  <= '0;
            step_q <= '0;
            wbo_q  <= '0;
        end else if (accept) begin
            st_q   <= S_BASE;
            mask_q <= cmd_mask;
            base_q <= cmd_base;
            ctl_q  <= '{pre_inc: cmd_pre_inc, ascend: cmd_ascend,
                        usr_bank: cmd_usr_bank, wb_en: cmd_wb_en, is_load: cmd_is_load};
            off_q  <= so_in;
            step_q <= st_in;
            wbo_q  <= wb_in;
        end else if (fire) begin
            unique case (st_q)
                S_BASE: st_q <= (mask_q != '0) ? S_XFER : (ctl_q.wb_en ? S_WB : S_IDLE);
                S_XFER: begin
                    mask_q <= low_rest;
                    off_q  <= off_q + step_q;
                    if (low_rest == '0) st_q <= ctl_q.wb_en ? S_WB : S_IDLE;
                end
                S_WB:    st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ldm_uop_seq_chk.sv
module ldm_uop_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       uop_valid,
    input logic       uop_ready,
    input logic [1:0] uop_kind,
    input logic [4:0] uop_reg,
    input logic       uop_force_usr,
    input logic [7:0] uop_offset,
    input logic       uop_last
);
    logic first_q;
    always_ff @(posedge clk) begin
        if (rst) first_q <= 1'b1;
        else if (cmd_valid && cmd_ready) first_q <= 1'b1;
        else if (uop_valid && uop_ready) first_q <= 1'b0;
    end

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_ready == !uop_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_reg)
                                   && $stable(uop_offset) && $stable(uop_last));
    p_last_ends_r2: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_ready && uop_last |=> !uop_valid);
    p_base_first_r3: assert property (@(posedge clk) disable iff (rst)
        uop_valid && first_q |-> uop_kind == 2'd0 && uop_offset == 8'd0 && !uop_force_usr);
    p_force_r8: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_force_usr |-> uop_reg >= 5'd16);
    p_wb_last_r9: assert property (@(posedge clk) disable iff (rst)
        uop_valid && uop_kind == 2'd3 |-> uop_last);
endmodule

bind ldm_uop_seq ldm_uop_seq_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
    .uop_reg(uop_reg), .uop_force_usr(uop_force_usr), .uop_offset(uop_offset),
    .uop_last(uop_last)
);

// File: tb/ldm_uop_seq_test.sv
module ldm_uop_seq_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_ready;
    logic [15:0] cmd_mask = 0;
    logic [3:0] cmd_base = 0;
    logic cmd_pre_inc = 0, cmd_ascend = 0, cmd_usr_bank = 0, cmd_wb_en = 0, cmd_is_load = 0;
    logic uop_valid, uop_ready = 0;
    logic [1:0] uop_kind;
    logic [4:0] uop_reg;
    logic uop_force_usr;
    logic [7:0] uop_offset;
    logic uop_last;

    int checks = 0, errors = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldm_uop_seq uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pack(int k, int r, int f, int o, int l);
        return (k << 20) | (r << 12) | (f << 11) | ((o & 255) << 1) | l;
    endfunction

    // reference model: builds expected stream from the requirements
    task automatic model(input logic [15:0] m, input int b, input bit p, u, s, w, l);
        int n, off, total, idx;
        n = $countones(m);
        total = n + 1 + (w ? 1 : 0);
        idx = 1;
        exp_q.push_back(pack(0, b, 0, 0, total == 1));          // R3
        off = u ? 0 : 4*n - 4;                                   // R5
        if (p) off += 4;
        for (int r = 0; r < 16; r++) if (m[r]) begin             // R4
            idx++;
            exp_q.push_back(pack(l ? 1 : 2, s ? r + 16 : r, s, off, idx == total)); // R7 R8
            off += u ? 4 : -4;                                   // R6
        end
        if (w) exp_q.push_back(pack(3, b, 0, u ? 4*n : -4*n, 1)); // R9 R12
    endtask

    task automatic run(input logic [15:0] m, input int b, input bit p, u, s, w, l, input int stall);
        int got, n;
        @(negedge clk);
        chk("R1", cmd_ready, 1);
        cmd_valid = 1; cmd_mask = m; cmd_base = b[3:0];
        cmd_pre_inc = p; cmd_ascend = u; cmd_usr_bank = s; cmd_wb_en = w; cmd_is_load = l;
        model(m, b, p, u, s, w, l);
        n = exp_q.size();
        @(negedge clk);
        // keep offering a different command: must be ignored (R10)
        cmd_mask = ~m; cmd_base = ~b[3:0]; cmd_is_load = ~l;
        got = 0;
        while (exp_q.size() > 0) begin
            bit rdy;
            rdy = (stall == 0) || ($urandom_range(0, 2) != 0);
            uop_ready = rdy;
            chk("R10", cmd_ready, 0);
            chk("R2", uop_valid, 1);
            if (rdy && uop_valid) begin
                chk("R2-R9 stream", pack(uop_kind, uop_reg, uop_force_usr, uop_offset, uop_last),
                    exp_q.pop_front());
                got++;
            end else if (!rdy) begin
                int hk;
                hk = pack(uop_kind, uop_reg, uop_force_usr, uop_offset, uop_last);
                @(negedge clk);
                chk("R11", pack(uop_kind, uop_reg, uop_force_usr, uop_offset, uop_last), hk);
                continue;
            end
            @(negedge clk);
        end
        uop_ready = 0; cmd_valid = 0;
        chk("R2 count", got, n);
        chk("R2 end", uop_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", uop_valid, 0);
        chk("R1", cmd_ready, 1);
        rst = 0;
        run(16'h00F0, 3, 0, 1, 0, 1, 1, 0);
        run(16'h8001, 13, 1, 0, 0, 1, 0, 0);
        run(16'h0A5A, 2, 0, 0, 1, 0, 1, 1);
        run(16'hFFFF, 0, 1, 1, 1, 1, 0, 1);
        run(16'hFFFF, 7, 1, 0, 0, 1, 1, 1);
        run(16'h0000, 5, 0, 1, 0, 1, 0, 0);   // R12
        run(16'h0000, 9, 1, 0, 1, 0, 1, 1);   // R12
        for (int t = 0; t < 40; t++)
            run(16'($urandom), $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule